// File: doc/BRIEF.md
# Data-EEPROM write timing engine

This block accepts byte and 32-bit word writes into a small data-EEPROM model and times each one. When a write is accepted, it looks at the bits the write will replace. If they are all zero, it runs a single program phase. If any of them is one, it runs an erase phase first and then the program phase. Each phase lasts `TPROG` clock cycles, so a write takes either one or two program periods. A fixed-time input forces the erase-then-program path on every write, so that every write takes the same time.

While a write is in flight, `busy` is high and the memory is stalled. Further write strobes are ignored, and the read port reports its data as not valid. When the program phase commits the new value, `done` pulses for one cycle and `busy` drops on the same clock edge. The memory contents can be observed one word at a time through a combinational read port.

Top module: `eeprom_write_timer`

## Requirements
- R1: After reset, `busy` and `done` are 0, `rdValid` is 1, and every memory word reads 0.
- R2: A write accepted with `fixedTime`=0 whose target bits are all zero keeps `busy` high for exactly `TPROG` cycles.
- R3: A write accepted with `fixedTime`=0 whose target holds at least one 1 bit keeps `busy` high for exactly 2*`TPROG` cycles.
- R4: A write accepted with `fixedTime`=1 keeps `busy` high for exactly 2*`TPROG` cycles, whatever the target holds.
- R5: A byte write (`wrWord`=0) targets word `wrAddr[ADDR_W-1:2]`, lane `wrAddr[1:0]` (lane k is bits 8k+7..8k), and takes its data from `wrData[7:0]`. Only that lane is considered for the zero test, is erased and is programmed; the other three lanes keep their values.
- R6: A word write (`wrWord`=1) targets word `wrAddr[ADDR_W-1:2]` and ignores `wrAddr[1:0]`. All 32 bits are used for the zero test, and the whole word is replaced by `wrData`.
- R7: `done` is a one-cycle pulse. It is raised on the edge where `busy` falls and at no other time.
- R8: A write is accepted only when `wrStb` is high while `busy` is low. A strobe raised while busy is ignored and changes no memory word. `rdValid` is 0 for as long as `busy` is 1.
- R9: `rdData` combinationally shows memory word `rdAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Write request, sampled on the clock edge |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrData | input | 32 | Write data; a byte write uses bits 7..0 |
| wrWord | input | 1 | 1 = word write, 0 = byte write |
| fixedTime | input | 1 | Forces the erase-then-program path |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse when a write commits |
| rdAddr | input | IDX_W | Word index for the read port |
| rdData | output | 32 | Word at `rdAddr` |
| rdValid | output | 1 | Read data not stalled |

## Verification
The bench builds the block with `WORDS`=8 and `TPROG`=3. With these values, every byte lane of every word can be swept, and the whole memory can be compared against a bench model after each write. Because the one-period and two-period durations of 3 and 6 cycles are short, they can be counted exactly, and a strobe can be raised in the middle of a write to confirm that it is ignored. The passes lead the zero test into both outcomes: fresh lanes, overwritten lanes, a zeroed lane inside an otherwise nonzero word, whole-word writes with unaligned low address bits, and forced fixed-time writes.

// File: rtl/eeprom_wt_pkg.sv
package eeprom_wt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_PROG} wtState_t;

  typedef struct packed {
    logic load;
    logic eraseNow;
    logic progNow;
  } dpCtrl_t;
endpackage

// File: rtl/eeprom_wt_ctrl.sv
module eeprom_wt_ctrl
  import eeprom_wt_pkg::*;
#(
  parameter int TPROG = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrStb,
  input  logic    fixedTime,
  input  logic    targetZero,
  output dpCtrl_t ctl,
  output logic    busy,
  output logic    done
);
  localparam int CNT_W = $clog2(TPROG + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TPROG - 1);

  wtState_t state;
  logic [CNT_W-1:0] cnt;
  logic accept;

  assign accept = wrStb && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    ctl          = '0;
    ctl.load     = accept;
    ctl.eraseNow = (state == ST_ERASE) && (cnt == '0);
    ctl.progNow  = (state == ST_PROG) && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= ctl.progNow;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= (fixedTime || !targetZero) ? ST_ERASE : ST_PROG;
            cnt   <= RELOAD;
          end
        end
        ST_ERASE: begin
          if (cnt == '0) begin
            state <= ST_PROG;
            cnt   <= RELOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PROG: begin
          if (cnt == '0) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_wt_datapath.sv
module eeprom_wt_datapath
  import eeprom_wt_pkg::*;
#(
  parameter int WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtrl_t                  ctl,
  input  logic [$clog2(WORDS)+1:0] wrAddr,
  input  logic [31:0]              wrData,
  input  logic                     wrWord,
  input  logic [$clog2(WORDS)-1:0] rdAddr,
  output logic [31:0]              rdData,
  output logic                     targetZero
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int ADDR_W = IDX_W + 2;

  logic [31:0] mem [WORDS];
  logic [IDX_W-1:0] curIdx;
  logic [1:0] curLane;
  logic [31:0] curData;
  logic curWord;

  logic [IDX_W-1:0] inIdx;
  logic [1:0] inLane;
  logic [31:0] inWordVal;

  assign inIdx     = wrAddr[ADDR_W-1:2];
  assign inLane    = wrAddr[1:0];
  assign inWordVal = mem[inIdx];
  assign targetZero = wrWord ? (inWordVal == '0) : (inWordVal[inLane*8 +: 8] == 8'h00);
  assign rdData = mem[rdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx  <= '0;
      curLane <= '0;
      curData <= '0;
      curWord <= 1'b0;
    end else if (ctl.load) begin
      curIdx  <= inIdx;
      curLane <= inLane;
      curData <= wrData;
      curWord <= wrWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (ctl.eraseNow) begin
      if (curWord) mem[curIdx] <= '0;
      else mem[curIdx][curLane*8 +: 8] <= 8'h00;
    end else if (ctl.progNow) begin
      if (curWord) mem[curIdx] <= curData;
      else mem[curIdx][curLane*8 +: 8] <= curData[7:0];
    end
  end
endmodule

// File: rtl/eeprom_write_timer.sv
module eeprom_write_timer
  import eeprom_wt_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int TPROG = 16,
  localparam int IDX_W = $clog2(WORDS),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              wrWord,
  input  logic              fixedTime,
  output logic              busy,
  output logic              done,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [31:0]       rdData,
  output logic              rdValid
);
  dpCtrl_t ctl;
  logic targetZero;

  eeprom_wt_ctrl #(.TPROG(TPROG)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .fixedTime(fixedTime),
    .targetZero(targetZero), .ctl(ctl), .busy(busy), .done(done)
  );

  eeprom_wt_datapath #(.WORDS(WORDS)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrAddr(wrAddr), .wrData(wrData),
    .wrWord(wrWord), .rdAddr(rdAddr), .rdData(rdData), .targetZero(targetZero)
  );

  assign rdValid = !busy;
endmodule

// File: rtl/eeprom_wt_checker.sv
module eeprom_wt_checker #(
  parameter int TPROG = 16
) (
  input logic clk,
  input logic rstN,
  input logic wrStb,
  input logic fixedTime,
  input logic busy,
  input logic done
);
  localparam int LEN_W = $clog2(2 * TPROG + 1) + 1;
  logic [LEN_W-1:0] busyLen;
  logic fixedSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyLen   <= '0;
      fixedSeen <= 1'b0;
    end else begin
      busyLen <= busy ? busyLen + 1'b1 : '0;
      if (wrStb && !busy) fixedSeen <= fixedTime;
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !busy) |=> busy);

  // R2, R3: every write lasts one or two program periods
  assert_length_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (int'(busyLen) == TPROG || int'(busyLen) == 2 * TPROG));

  assert_fixed_length_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && fixedSeen) |-> int'(busyLen) == 2 * TPROG);
endmodule

bind eeprom_write_timer eeprom_wt_checker #(.TPROG(TPROG)) chk_i (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .fixedTime(fixedTime),
  .busy(busy), .done(done)
);

// File: tb/eeprom_write_timer_tb.sv
module eeprom_write_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 8;
  localparam int TP = 3;
  localparam int IDX_W = $clog2(WORDS);
  localparam int ADDR_W = IDX_W + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStb = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic wrWord = 1'b0;
  logic fixedTime = 1'b0;
  logic busy, done, rdValid;
  logic [IDX_W-1:0] rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails = 0;
  logic [31:0] model [WORDS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  eeprom_write_timer #(.WORDS(WORDS), .TPROG(TP)) dut_i (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .wrWord(wrWord), .fixedTime(fixedTime), .busy(busy), .done(done),
    .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sweepMem(input string req);
    for (int i = 0; i < WORDS; i++) begin
      rdAddr = IDX_W'(i);
      #1;
      check(req, rdData, model[i]);
    end
  endtask

  task automatic doWrite(input int idx, input int lane, input logic [31:0] d,
                         input logic isWord, input logic fx, input logic poke);
    logic [31:0] old;
    int expN, n;
    string req;
    old = isWord ? model[idx] : {24'h0, model[idx][lane*8 +: 8]};
    expN = (old != 0 || fx) ? 2 * TP : TP;
    req = fx ? "R4" : (old != 0 ? "R3" : "R2");
    @(negedge clk);
    wrAddr = ADDR_W'(idx * 4 + lane);
    wrData = d; wrWord = isWord; fixedTime = fx; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; fixedTime = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (n == 1) check("R8 stall", {31'h0, rdValid}, 32'h0);
      if (poke && n == 2) begin
        wrAddr = ADDR_W'(((idx + 1) % WORDS) * 4);
        wrData = ~d; wrWord = 1'b1; wrStb = 1'b1;
      end else begin
        wrStb = 1'b0;
      end
      @(negedge clk);
    end
    wrStb = 1'b0;
    check(req, n, expN);
    check("R7 done raised", {31'h0, done}, 32'h1);
    if (isWord) model[idx] = d;
    else model[idx][lane*8 +: 8] = d[7:0];
    @(negedge clk);
    check("R7 done one cycle", {31'h0, done}, 32'h0);
    sweepMem(poke ? "R8 ignored strobe" : (isWord ? "R6" : "R5"));
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy", {31'h0, busy}, 32'h0);
    check("R1 done", {31'h0, done}, 32'h0);
    check("R1 rdValid", {31'h0, rdValid}, 32'h1);
    sweepMem("R1 mem");

    // R2/R5: fresh lanes; R8: strobe in the middle of some writes
    for (int w = 0; w < WORDS; w++)
      for (int l = 0; l < 4; l++)
        doWrite(w, l, 32'(w * 4 + l + 1), 1'b0, 1'b0, l == 1);
    // R3: overwrite nonzero lanes
    for (int w = 0; w < WORDS; w++)
      for (int l = 0; l < 4; l++)
        doWrite(w, l, 32'(8'hA0 | l), 1'b0, 1'b0, 1'b0);
    // R5: zero test on the addressed lane only
    for (int w = 0; w < WORDS; w++) begin
      doWrite(w, 0, 32'h0, 1'b0, 1'b0, 1'b0);
      doWrite(w, 0, 32'h5A, 1'b0, 1'b0, 1'b0);
    end
    // R6: word writes, low address bits ignored
    for (int w = 0; w < WORDS; w++) begin
      doWrite(w, 2, 32'h0, 1'b1, 1'b0, 1'b0);
      doWrite(w, 3, 32'h1234_5678 + 32'(w), 1'b1, 1'b0, 1'b0);
    end
    // R4: fixed time on nonzero and on zero targets
    for (int w = 0; w < WORDS; w++) begin
      doWrite(w, 0, 32'h0, 1'b1, 1'b1, 1'b0);
      doWrite(w, 1, 32'hC0DE_0000 | 32'(w), 1'b1, 1'b1, 1'b0);
      doWrite(w, 3, 32'h0, 1'b0, 1'b1, 1'b0);
    end
    // R9: read port follows rdAddr
    sweepMem("R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule